// File: doc/BRIEF.md
# Serial-Controlled Clock Fan-Out Enable

This block copies one reference clock onto eighteen non-inverting outputs. Each output can be switched on or off on its own through a receive-only two-wire serial port. The port is a slave receiver with a fixed 7-bit address. It accepts a write, acknowledges every byte and loads the bytes into the enable bank. The first data byte of each transfer always goes to the first control byte, so there is no register pointer. To change a later byte, every earlier byte must be sent again. The port never acknowledges a read and never drives register contents onto the data line.

A disabled output is parked low and does not toggle. The enable bits only reach the output gate while the reference clock is low, so switching an output on or off never produces a short pulse. A global enable input puts all eighteen outputs in high impedance when it is low, whatever the bank holds. After reset every enable bit is set and every output follows the reference clock.

The serial lines are sampled through a two-flop synchroniser in the system clock domain. The system clock must be several times faster than the serial clock. The reference clock is assumed to change away from the rising edge of the system clock.

Top module: `clk_fanout_ctl`

## Requirements
- R1: With the global enable high and every enable bit set, each output equals the reference clock.
- R2: After reset every enable bit is 1, and a change at an output gate always takes the value held in the enable bank.
- R3: An output whose enable bit is 0 reads logic 0 (not high impedance) while the global enable is high.
- R4: While the global enable is low, all outputs are high impedance.
- R5: The address byte is seven address bits followed by a direction bit (0 = write), MSB first. Only the address DEV_ADDR (default 7'h69, so the byte is 8'hD2) with direction 0 is acknowledged. Any other address, and any read (8'hD3), gets no acknowledge, and the bytes that follow change nothing.
- R6: Data bytes fill control bytes 0, 1 and 2 in order from the start of each transfer. Bit j of byte k enables output 8k+j. Bits 2..7 of byte 2 are ignored. Bytes past the third are acknowledged and ignored.
- R7: Each byte is received MSB first. The block pulls the data line low from the falling serial clock edge after the eighth bit until the falling edge that ends the ninth clock, and releases it afterwards.
- R8: A stop or a repeated start ends the transfer. Completed bytes stay in effect and a partly received byte is discarded.
- R9: An output gate changes only while the reference clock is low, so no output shows a shortened pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock to be fanned out |
| out_en | input | 1 | Global output enable; low puts all outputs in high impedance |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | When 1, the open-drain data line is pulled low (acknowledge) |
| clk_out | output | NUM_OUT | Gated copies of the reference clock |

## Verification
The bound checker watches, on every cycle, four things. It checks that disabled outputs stay low while globally enabled and that gate updates happen only while the reference clock is low. It also checks that the gate always takes the value stored in the enable bank, and that the acknowledge drive changes only while the synchronised serial clock is low. Address matching, the in-order filling of control bytes, the discarding of partial bytes at a stop or repeated start, and the high-impedance state under the global enable depend on whole transfers. Only the bench's sequences of serial transactions, followed by checks of the output pattern, can show them.

// File: rtl/clkfan_pkg.sv
// Package: shared types for the clock fan-out enable block.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package clkfan_pkg;

    // Receiver phases of one serial transfer
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK
    } rx_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/clkfan_sync2.sv
// Module: two-flop synchroniser for a bundle of asynchronous inputs.
// Assumes inputs idle at RST_VAL, so reset loads that value into both stages.
module clkfan_sync2 #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1;

    // Two-stage capture into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/clkfan_serial_rx.sv
// Module: write-only two-wire serial slave receiver.
// Detects start/stop, matches DEV_ADDR with write direction, acknowledges each
// byte and emits a one-cycle write strobe with a byte index that restarts at 0
// on every start. Assumes synchronised inputs, oversampled by clk.
module clkfan_serial_rx
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         NUM_BYTES = 3,
    localparam int        IDX_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(NUM_BYTES);

    rx_state_e          state;
    logic               scl_d, sda_d;
    logic [3:0]         bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [IDX_W-1:0]   byte_idx;
    logic               start_c, stop_c, scl_rise, scl_fall, shifting;

    // Previous line values for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Bus events decoded from current and previous samples
    always_comb begin
        start_c  = scl_s && scl_d && sda_d && !sda_s;
        stop_c   = scl_s && scl_d && !sda_d && sda_s;
        scl_rise = scl_s && !scl_d;
        scl_fall = !scl_s && scl_d;
        shifting = (state == RX_ADDR) || (state == RX_DATA);
    end

    // Transfer sequencing, shifting, acknowledge drive and byte commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_c) begin
                state    <= RX_ADDR;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                state    <= RX_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                if (scl_rise && shifting && (bit_cnt < 4'd8)) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (scl_fall) begin
                    case (state)
                        RX_ADDR: begin
                            if (bit_cnt == 4'd8) begin
                                bit_cnt <= '0;
                                if ((shreg[7:1] == DEV_ADDR) && !shreg[0]) begin
                                    state    <= RX_ADDR_ACK;
                                    sda_pull <= 1'b1;
                                end else begin
                                    state <= RX_IDLE;
                                end
                            end
                        end
                        RX_ADDR_ACK: begin
                            sda_pull <= 1'b0;
                            state    <= RX_DATA;
                        end
                        RX_DATA: begin
                            if (bit_cnt == 4'd8) begin
                                bit_cnt  <= '0;
                                wr_stb   <= 1'b1;
                                wr_idx   <= byte_idx;
                                wr_data  <= shreg;
                                sda_pull <= 1'b1;
                                state    <= RX_DATA_ACK;
                                if (byte_idx != IDX_SAT) begin
                                    byte_idx <= byte_idx + 1'b1;
                                end
                            end
                        end
                        RX_DATA_ACK: begin
                            sda_pull <= 1'b0;
                            state    <= RX_DATA;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/clkfan_enable_bank.sv
// Module: per-output enable register bank and glitch-free output gating.
// Byte k bit j of a write controls output 8k+j; indices past the bank are
// ignored. Gate bits copy the bank only while ref_clk is low, which assumes
// ref_clk changes away from the rising edge of clk.
module clkfan_enable_bank
    import clkfan_pkg::*;
#(
    parameter int  NUM_OUT   = 18,
    localparam int NUM_BYTES = (NUM_OUT + BYTE_W - 1) / BYTE_W,
    localparam int IDX_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               ref_clk,
    output logic [NUM_OUT-1:0] en_q,
    output logic [NUM_OUT-1:0] gate_q,
    output logic [NUM_OUT-1:0] clk_gated
);

    // Load the addressed byte's bits into the enable bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (wr_stb) begin
            for (int i = 0; i < NUM_OUT; i++) begin
                if (wr_idx == IDX_W'(i / BYTE_W)) begin
                    en_q[i] <= wr_data[i % BYTE_W];
                end
            end
        end
    end

    // Copy enables to the gate only while the reference clock is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '1;
        end else if (!ref_clk) begin
            gate_q <= en_q;
        end
    end

    // One AND gate per output
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
        assign clk_gated[g] = ref_clk & gate_q[g];
    end

endmodule

// File: rtl/clk_fanout_ctl.sv
// Module: top of the serial-controlled clock fan-out.
// Synchronises the serial lines, runs the slave receiver, holds the enable
// bank and drives the outputs, which go high impedance when out_en is low.
// Assumes clk is several times faster than the serial clock.
module clk_fanout_ctl
    import clkfan_pkg::*;
#(
    parameter int         NUM_OUT  = 18,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_clk,
    input  logic               out_en,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    output logic [NUM_OUT-1:0] clk_out
);

    localparam int NUM_BYTES = (NUM_OUT + BYTE_W - 1) / BYTE_W;
    localparam int IDX_W     = $clog2(NUM_BYTES + 1);

    logic [1:0]         lines_s;
    logic               scl_s, sda_s;
    logic               wr_stb;
    logic [IDX_W-1:0]   wr_idx;
    logic [BYTE_W-1:0]  wr_data;
    logic [NUM_OUT-1:0] en_q, gate_q, clk_gated;

    clkfan_sync2 #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_in, sda_in}),
        .q_sync  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    clkfan_serial_rx #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .sda_pull (sda_pull),
        .wr_stb   (wr_stb),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    clkfan_enable_bank #(.NUM_OUT(NUM_OUT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .ref_clk   (ref_clk),
        .en_q      (en_q),
        .gate_q    (gate_q),
        .clk_gated (clk_gated)
    );

    // Output drivers with global high-impedance control
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_drv
        assign clk_out[g] = out_en ? clk_gated[g] : 1'bz;
    end

endmodule

// File: rtl/clkfan_checker.sv
// Module: cycle-level property checker bound into clk_fanout_ctl.
// Observes ports and the signals passed between the sub-blocks.
module clkfan_checker #(
    parameter int NUM_OUT = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ref_clk,
    input logic               out_en,
    input logic               scl_s,
    input logic               sda_pull,
    input logic [NUM_OUT-1:0] en_q,
    input logic [NUM_OUT-1:0] gate_q,
    input logic [NUM_OUT-1:0] clk_out
);

    // R3: disabled outputs read low while globally enabled
    a_r3_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> ((clk_out & ~gate_q) == '0));

    // R9: gate bits move only while the reference clock was low
    a_r9_gate_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q != $past(gate_q)) |-> !$past(ref_clk));

    // R2: a gate change always takes the stored enable value
    a_r2_gate_from_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q != $past(gate_q)) |-> (gate_q == $past(en_q)));

    // R7: acknowledge drive changes only while the serial clock is low
    a_r7_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

endmodule

bind clk_fanout_ctl clkfan_checker #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_clk  (ref_clk),
    .out_en   (out_en),
    .scl_s    (scl_s),
    .sda_pull (sda_pull),
    .en_q     (en_q),
    .gate_q   (gate_q),
    .clk_out  (clk_out)
);

// File: tb/clk_fanout_ctl_tb.sv
`timescale 1ns/1ps
// Bench: table of serial write transfers with expected output patterns,
// then directed cases for reset, high impedance, partial bytes and restarts.
module clk_fanout_ctl_tb;

    localparam int NUM_OUT = 18;
    localparam int H       = 8;

    typedef struct packed {
        logic [7:0]  addr;
        logic [2:0]  nbytes;
        logic [31:0] data;
        logic        ack;
        logic [17:0] en;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hD2, 3'd3, 32'h00000000, 1'b1, 18'h00000},
        '{8'hD2, 3'd3, 32'hFFFF0300, 1'b1, 18'h3FFFF},
        '{8'hD2, 3'd1, 32'h0F000000, 1'b1, 18'h3FF0F},
        '{8'hD4, 3'd3, 32'h00000000, 1'b0, 18'h3FF0F},
        '{8'hD3, 3'd0, 32'h00000000, 1'b0, 18'h3FF0F},
        '{8'hD2, 3'd2, 32'hA53C0000, 1'b1, 18'h33CA5},
        '{8'hD2, 3'd3, 32'h0180FE00, 1'b1, 18'h28001},
        '{8'hD2, 3'd4, 32'hFFFF0100, 1'b1, 18'h1FFFF}
    };

    logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, out_en = 1'b1;
    logic scl = 1'b1, sda_m = 1'b1;
    wire               sda_pull;
    wire [NUM_OUT-1:0] clk_out;
    wire               sda_line = sda_m & ~sda_pull;

    int checks = 0, fails = 0, rc = 0, glitches = 0;
    bit done = 1'b0, mon_on = 1'b0;
    logic [NUM_OUT-1:0] prev_out = '0;
    logic prev_ref = 1'b0, prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    clk_fanout_ctl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .out_en   (out_en),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .clk_out  (clk_out)
    );

    // Reference clock: period of eight system clocks, driven on falling edges
    always @(negedge clk) begin
        if (rc == 3) begin
            rc <= 0;
            ref_clk <= ~ref_clk;
        end else begin
            rc <= rc + 1;
        end
    end

    // R9 monitor: an output may only move when the reference clock moves
    always @(posedge clk) begin
        #1;
        if (mon_on && out_en && prev_oe && (clk_out != prev_out) && (ref_clk == prev_ref))
            glitches++;
        prev_out = clk_out;
        prev_ref = ref_clk;
        prev_oe  = out_en;
    end

    task automatic note(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; idle(H);
        sda_m = 1'b0; idle(H);
        scl = 1'b0; idle(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; idle(H);
        scl = 1'b1; idle(H);
        sda_m = 1'b0; idle(H);
        scl = 1'b0; idle(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(H);
        scl = 1'b1; idle(H);
        sda_m = 1'b1; idle(H);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = v[7-i]; idle(H);
            scl = 1'b1; idle(H);
            scl = 1'b0; idle(H);
        end
    endtask

    // Byte plus ninth clock; ack must be low before and during the high phase (R7)
    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit early, late;
        send_bits(v, 8);
        sda_m = 1'b1; idle(H);
        early = !sda_line;
        scl = 1'b1; idle(H);
        late = !sda_line;
        scl = 1'b0; idle(H);
        ack = early & late;
        note(sda_line === 1'b1, "R7 ack released after ninth clock", {31'd0, sda_line}, 32'd1);
    endtask

    task automatic check_fanout(input string req, input logic [NUM_OUT-1:0] exp_en);
        bit ok = 1'b1;
        logic [NUM_OUT-1:0] got = '0, want = '0;
        for (int k = 0; k < 16; k++) begin
            @(posedge clk); #1;
            if (clk_out !== (ref_clk ? exp_en : '0)) begin
                ok = 1'b0;
                got = clk_out;
                want = ref_clk ? exp_en : '0;
            end
        end
        note(ok, req, 32'(got), 32'(want));
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a, d;
        idle(6);
        rst_n = 1'b1;
        idle(4);
        mon_on = 1'b1;

        // R2 / R1: all outputs follow the reference after reset
        note(sda_pull === 1'b0, "R7 no ack drive after reset", {31'd0, sda_pull}, 32'd0);
        check_fanout("R2 R1 reset state all enabled", '1);

        // Table of transfers: R5 addressing, R6 ordering, R3 parking low
        for (int v = 0; v < 8; v++) begin
            bus_start();
            send_byte(VECS[v].addr, a);
            note(a == VECS[v].ack, "R5 address acknowledge", {31'd0, a}, {31'd0, VECS[v].ack});
            for (int b = 0; b < int'(VECS[v].nbytes); b++) begin
                send_byte(VECS[v].data[31-8*b -: 8], d);
                note(d == VECS[v].ack, "R7 data byte acknowledge", {31'd0, d}, {31'd0, VECS[v].ack});
            end
            bus_stop();
            idle(2*H);
            check_fanout("R6 R3 output pattern after transfer", VECS[v].en);
        end

        // R4: global enable low floats every output
        out_en = 1'b0;
        idle(2);
        note(clk_out === {NUM_OUT{1'bz}}, "R4 outputs high impedance", 32'(clk_out), 32'h0);
        out_en = 1'b1;
        idle(2);
        check_fanout("R4 R1 outputs return with enable", 18'h1FFFF);

        // R8: stop in the middle of a byte discards it
        bus_start();
        send_byte(8'hD2, a);
        note(a, "R5 address acknowledge", {31'd0, a}, 32'd1);
        send_bits(8'h00, 5);
        bus_stop();
        idle(2*H);
        check_fanout("R8 partial byte discarded at stop", 18'h1FFFF);

        // R8 / R6: repeated start ends transfer; new transfer restarts at byte 0
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, d);
        note(d, "R7 data byte acknowledge", {31'd0, d}, 32'd1);
        send_bits(8'hFF, 4);
        bus_rstart();
        send_byte(8'hD2, a);
        note(a, "R5 address acknowledge after restart", {31'd0, a}, 32'd1);
        send_byte(8'h33, d);
        bus_stop();
        idle(2*H);
        check_fanout("R8 R6 restart refills first byte", 18'h1FF33);

        // R9: no shortened output pulse seen during any change
        note(glitches == 0, "R9 no runt pulses", 32'(glitches), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule